// File: doc/BRIEF.md
# Chained Serial Readout Shifter

This block is the data-output half of a multichannel converter's serial slave port. When a data-ready strobe arrives while the port is deselected, it captures one frame: a 24-bit status word followed by one 16-bit word per channel. The host then clocks the frame out on the serial output, most significant bit first. The serial clock, select and chain input are asynchronous to the system clock. Each is brought in through a synchronizer, and every change on the output is registered.

A configuration input picks one of two wirings. In shared-bus mode every device has its own select line. The output is released whenever its device is deselected, and continued clocking replays the captured frame. In chained mode, select and clock are common to all devices, and each device's output feeds the chain input of the device nearer the host. The block first sends its own frame. It then sends exactly one filler bit, then the bits it received on its chain input. It never replays its own frame. An unused chain input is tied low, so bits past the end of the chain read as zero.

Top module: `spi_chain_readout`

## Requirements
- R1: `dout_oe` is low no later than three system clocks after `cs_n` goes high and stays low while `cs_n` stays high. It is high while `cs_n` is low.
- R2: A frame leaves as `frame_in` from its most significant bit down. Bits FRAME_W-1 to FRAME_W-24 form the status word, and each following 16 bits form one channel word, channel 0 first.
- R3: `dout` changes only a few system clocks after a rising edge of `sclk`. It holds its value through the rest of the high phase and the whole low phase, so the host can sample it on the falling edge.
- R4: `frame_in` is captured only by a `data_rdy` pulse that arrives while `cs_n` is high. A pulse while `cs_n` is low changes neither the frame being read nor the frame read after the next select.
- R5: Raising `cs_n` at any point abandons the read. The next select starts again at the status word's most significant bit.
- R6: With `chain_mode` = 0, the frame repeats from its first bit once all FRAME_W bits have been clocked out, for as long as clocking continues.
- R7: With `chain_mode` = 1, rising edge FRAME_W+1 sends one filler bit. Rising edge FRAME_W+1+k (k >= 1) sends the `chain_in` value sampled at falling edge k.
- R8: With `chain_mode` = 1, the own frame is never repeated. When the chain input is tied to 0, every bit after the forwarded data is 0.
- R9: Synchronous reset drives `dout` to 0 and `dout_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_mode | input | 1 | 1 selects chained wiring, 0 selects shared-bus wiring |
| data_rdy | input | 1 | One-cycle pulse that marks a new frame on `frame_in` |
| frame_in | input | FRAME_W | Status word in the top 24 bits, then channel words, channel 0 first |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low select, asynchronous |
| chain_in | input | 1 | Serial output of the next device down the chain, tied to 0 if unused |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
The assertions take for granted that `sclk` and `cs_n` each hold a level for more cycles than the synchronizer is deep. They also assume that `cs_n` does not change inside a serial clock phase, so that each rising edge is seen exactly once and the select state is settled when an edge arrives. The bench holds every `sclk` phase for eight system clocks, and it changes `cs_n` and `data_rdy` only with `sclk` low and with ten clocks of margin. It drives the chain input from a second copy of the block, whose own chain input is tied low. That copy stands in for the downstream device, and it makes the filler slot and the trailing zeros fall at positions that can be predicted.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int STATUS_BITS = 24;
  localparam int CH_WORD_BITS = 16;

  function automatic int frame_width(input int n_ch, input int st_w, input int w_w);
    return st_w + n_ch * w_w;
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else if (i == 0) stage_q[i] <= d;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sclk_edge.sv
module sclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  output logic rise_evt,
  output logic fall_evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else prev_q <= sclk_s;
  end

  assign rise_evt = sclk_s & ~prev_q;
  assign fall_evt = ~sclk_s & prev_q;
endmodule

// File: rtl/chain_fwd.sv
module chain_fwd (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic fall_evt,
  input  logic chain_s,
  output logic fwd_bit
);
  always_ff @(posedge clk) begin
    if (rst || cs_s) fwd_bit <= 1'b0;
    else if (fall_evt) fwd_bit <= chain_s;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 88,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chain_mode,
  input  logic               cs_s,
  input  logic               rise_evt,
  input  logic               data_rdy,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               fwd_bit,
  output logic               dout,
  output logic               dout_oe,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      shreg   <= '0;
      bit_cnt <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= ~cs_s;
      if (data_rdy && cs_s) frame_q <= frame_in;
      if (cs_s) begin
        shreg   <= frame_q;
        bit_cnt <= '0;
        dout    <= 1'b0;
      end else if (rise_evt) begin
        dout <= shreg[FRAME_W-1];
        if (bit_cnt == LAST && !chain_mode) begin
          shreg   <= frame_q;
          bit_cnt <= '0;
        end else begin
          shreg <= {shreg[FRAME_W-2:0], fwd_bit};
          if (bit_cnt != LAST) bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_chain_readout.sv
module spi_chain_readout #(
  parameter int N_CH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = spi_chain_pkg::frame_width(N_CH, spi_chain_pkg::STATUS_BITS,
                                                      spi_chain_pkg::CH_WORD_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chain_mode,
  input  logic               data_rdy,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               chain_in,
  output logic               dout,
  output logic               dout_oe
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [2:0] raw_in, sync_out;
  logic sclk_s, cs_s, chain_s;
  logic rise_evt, fall_evt, fwd_bit;
  logic [CNT_W-1:0] bit_cnt;

  assign raw_in = {cs_n, sclk, chain_in};
  assign {cs_s, sclk_s, chain_s} = sync_out;

  bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  sclk_edge u_edge (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  chain_fwd u_fwd (
    .clk(clk), .rst(rst), .cs_s(cs_s), .fall_evt(fall_evt), .chain_s(chain_s),
    .fwd_bit(fwd_bit)
  );

  frame_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .chain_mode(chain_mode), .cs_s(cs_s), .rise_evt(rise_evt),
    .data_rdy(data_rdy), .frame_in(frame_in), .fwd_bit(fwd_bit),
    .dout(dout), .dout_oe(dout_oe), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/spi_chain_readout_chk.sv
module spi_chain_readout_chk #(
  parameter int FRAME_W = 88,
  parameter int CNT_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             dout,
  input logic             dout_oe,
  input logic             rise_evt,
  input logic             cs_s,
  input logic             fwd_bit,
  input logic [CNT_W-1:0] bit_cnt
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R1: a settled deselect releases the output
  assert_release_R1: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt > SYNC_STAGES) |-> !dout_oe);

  // R3: output moves only after a rising serial clock edge or while deselected
  assert_edge_only_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rise_evt) && !$past(cs_s)) |-> $stable(dout));

  // R9: reset leaves the output low and released
  assert_reset_out_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dout && !dout_oe));

  // R5: bit position never runs past the frame
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W - 1));

  // R7: filler slot is cleared by deselect before forwarding begins
  assert_filler_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> !fwd_bit);
endmodule

bind spi_chain_readout spi_chain_readout_chk #(
  .FRAME_W(FRAME_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .rise_evt(rise_evt), .cs_s(cs_s), .fwd_bit(fwd_bit), .bit_cnt(bit_cnt)
);

// File: tb/spi_chain_readout_test.sv
module spi_chain_readout_test;
  localparam int N_CH = 4;
  localparam int F = 24 + 16 * N_CH;

  typedef struct {
    logic  b;
    logic  chk;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chain_mode = 1'b0;
  logic rdy_up = 1'b0, rdy_dn = 1'b0;
  logic [F-1:0] frame_up = '0, frame_dn = '0;
  logic sclk = 1'b0, cs_n = 1'b1;
  logic dout, dout_oe, dn_dout, dn_oe, link;

  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;
  logic stab_on = 1'b0;
  logic smp_bit;
  event smp_ev;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  assign link = dn_oe ? dn_dout : 1'b0;

  spi_chain_readout #(.N_CH(N_CH)) uut (
    .clk(clk), .rst(rst), .chain_mode(chain_mode), .data_rdy(rdy_up), .frame_in(frame_up),
    .sclk(sclk), .cs_n(cs_n), .chain_in(link), .dout(dout), .dout_oe(dout_oe)
  );

  spi_chain_readout #(.N_CH(N_CH)) dn (
    .clk(clk), .rst(rst), .chain_mode(chain_mode), .data_rdy(rdy_dn), .frame_in(frame_dn),
    .sclk(sclk), .cs_n(cs_n), .chain_in(1'b0), .dout(dn_dout), .dout_oe(dn_oe)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [F-1:0] make_frame(input int seed);
    logic [F-1:0] f;
    for (int i = 0; i < F; i++) f[i] = (((i * seed) + (seed / 3) + i / 5) % 7) < 3;
    return f;
  endfunction

  // driver side: expected bits into the scoreboard
  task automatic push_frame(input logic [F-1:0] f, input int nbits, input string tag);
    for (int i = 0; i < nbits; i++) begin
      exp_t e;
      e.b = f[F-1-(i % F)];
      e.chk = 1'b1;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_const(input logic v, input logic chk, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.b = v;
      e.chk = chk;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // monitor side: compare each host-sampled bit
  always @(smp_ev) begin
    if (exp_q.size() == 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %b expected <none>", smp_bit);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.chk) check(smp_bit, e.b, e.tag);
    end
  end

  task automatic clock_bits(input int n);
    for (int i = 0; i < n; i++) begin
      logic s_mid, s_end, s_low;
      @(negedge clk) sclk = 1'b1;
      repeat (6) @(negedge clk);
      s_mid = dout;
      repeat (2) @(negedge clk);
      s_end = dout;
      sclk = 1'b0;
      smp_bit = s_end;
      -> smp_ev;
      repeat (4) @(negedge clk);
      s_low = dout;
      repeat (4) @(negedge clk);
      if (stab_on) begin
        check(s_mid, s_end, "R3 high phase");
        check(s_low, s_end, "R3 low phase");
      end
    end
  endtask

  task automatic select(input logic v);
    @(negedge clk) cs_n = v;
    repeat (10) @(negedge clk);
  endtask

  task automatic load(input logic [F-1:0] fu, input logic [F-1:0] fd);
    @(negedge clk);
    frame_up = fu;
    frame_dn = fd;
    rdy_up = 1'b1;
    rdy_dn = 1'b1;
    @(negedge clk);
    rdy_up = 1'b0;
    rdy_dn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [F-1:0] fa, fb, fc;
    fa = make_frame(11);
    fb = make_frame(29);
    fc = make_frame(47);

    repeat (10) @(negedge clk);
    check(dout, 1'b0, "R9 dout in reset");
    check(dout_oe, 1'b0, "R9 oe in reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(dout_oe, 1'b0, "R1 oe while deselected");

    // shared-bus mode: frame then replay
    load(fa, fb);
    select(1'b0);
    check(dout_oe, 1'b1, "R1 oe while selected");
    stab_on = 1'b1;
    push_frame(fa, F, "R2 frame order");
    clock_bits(F);
    stab_on = 1'b0;
    push_frame(fa, F, "R6 replay");
    clock_bits(F);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dout_oe, 1'b0, "R1 release latency");
    repeat (7) @(negedge clk);
    check(dout_oe, 1'b0, "R1 stays released");

    // abandoned read restarts at status word
    select(1'b0);
    push_frame(fa, 10, "R5 partial read");
    clock_bits(10);
    select(1'b1);
    select(1'b0);
    push_frame(fa, 30, "R5 restart");
    clock_bits(30);
    select(1'b1);

    // strobe while selected is ignored
    select(1'b0);
    push_frame(fa, F, "R4 strobe while selected");
    clock_bits(5);
    load(fc, fb);
    clock_bits(F - 5);
    select(1'b1);
    select(1'b0);
    push_frame(fa, 8, "R4 old frame kept");
    clock_bits(8);
    select(1'b1);
    load(fc, fb);
    select(1'b0);
    push_frame(fc, 24, "R4 capture while deselected");
    clock_bits(24);
    select(1'b1);

    // chained mode: own frame, filler, downstream frame, zeros
    chain_mode = 1'b1;
    load(fa, fb);
    select(1'b0);
    push_frame(fa, F, "R7 own frame");
    push_const(1'b0, 1'b0, 1, "R7 filler");
    push_frame(fb, F, "R7 forwarded frame");
    push_const(1'b0, 1'b1, 40, "R8 no replay");
    clock_bits(2 * F + 41);
    select(1'b1);
    check(dout_oe, 1'b0, "R1 chained release");

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule